// File: doc/BRIEF.md
# Keyed Configuration Index/Data Port

This block is the device side of a small configuration space reached through a two-byte window. Offset 0 of the window is an index port that names a register; offset 1 is a data port that reads or writes the register last named. The whole space is closed until the host writes an unlock key to the index port. A lock key closes it again. While it is open, a global register picks which logical-device bank is visible. A second global register returns a fixed chip identifier.

Only one bank, the embedded-controller bank, has contents. It holds an activate flag and a 16-bit base address split across two consecutive registers. The lower register number carries the low byte, which is the reverse of what many similar parts do. Firmware discovers the device by unlocking the space, reading the identifier, selecting the bank, testing the activate flag, reading the address and locking the space again.

The host side is a synchronous strobe interface. It has one address bit, a write strobe, a read strobe and byte-wide data. Read data is registered.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the space is locked, `rd_data` is 0xFF, the latched index is 0x00 and the selected logical device is 0x00. Once unlocked, the activate flag reads as parameter `ACT_RST` (default 1) and the base address reads as parameter `BASE_RST` (default 0x0A2E).
- R2: Writing the unlock key 0x55 to the index port (`cfg_addr`=0) while locked opens the space. While locked, any other index-port value leaves the state and the latched index unchanged.
- R3: While locked, every read returns 0xFF from either port, and data-port writes change no register.
- R4: Writing the lock key 0xAA to the index port while open closes the space. This write leaves the latched index unchanged.
- R5: While open, an index-port write of any value other than 0xAA latches that value as the register number. An index-port read returns the latched number.
- R6: Global register 0x07 holds the selected logical-device number. It can be written and read back through the data port, and its value chooses the visible bank.
- R7: Global register 0x20 reads the chip identifier: 0xC6 when `ID_ALT`=0 (default) and 0xC7 when `ID_ALT`=1. Writes to it are ignored.
- R8: With logical device 0x0C selected, register 0x30 bit 0 is the activate flag. Bits 7:1 read as zero, and only bit 0 of a write is stored.
- R9: With logical device 0x0C selected, register 0x66 holds base-address bits 7:0 and register 0x67 holds bits 15:8. Both can be written and read back.
- R10: With any other logical device selected, registers 0x30, 0x66 and 0x67 read as zero and writes to them are ignored. Indices with no register read as zero.
- R11: `rd_data` takes its new value at the clock edge that samples `rd_stb` high. It holds that value in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 1 | Port select: 0 index, 1 data |
| wr_stb | input | 1 | Write strobe, one cycle per access |
| rd_stb | input | 1 | Read strobe, one cycle per access |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Registered read byte |

## Verification
Every write takes effect at the clock edge that samples its strobe. A read issued in the very next cycle therefore already sees the new state. The read result is due one edge after `rd_stb` and is sampled on the falling edge that follows. All inputs are driven on falling edges, so the sample never races the edge that produces it. A behavioural model updated on the same rising edge is compared against `rd_data` on every falling edge. Directed reads additionally compare against literal values, and idle stretches confirm that the output holds between reads.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  typedef enum logic {
    ST_LOCKED = 1'b0,
    ST_OPEN   = 1'b1
  } lock_state_e;

  localparam logic [7:0] ID_CODE_PRI = 8'hC6;
  localparam logic [7:0] ID_CODE_ALT = 8'hC7;
  localparam logic [7:0] LOCKED_READ = 8'hFF;

  function automatic logic [7:0] pick_id(input bit alt);
    return alt ? ID_CODE_ALT : ID_CODE_PRI;
  endfunction

endpackage

// File: rtl/sio_key_lock.sv
module sio_key_lock
  import sio_cfg_pkg::*;
#(
  parameter int         DW         = 8,
  parameter logic [7:0] UNLOCK_KEY = 8'h55,
  parameter logic [7:0] LOCK_KEY   = 8'hAA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_wr,
  input  logic [DW-1:0] wr_data,
  output logic          unlocked,
  output logic          idx_load
);

  lock_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    idx_load = 1'b0;
    if (idx_wr) begin
      if (state_q == ST_LOCKED) begin
        if (wr_data == UNLOCK_KEY) state_d = ST_OPEN;
      end else begin
        if (wr_data == LOCK_KEY) state_d = ST_LOCKED;
        else                     idx_load = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_LOCKED;
    else        state_q <= state_d;
  end

  assign unlocked = (state_q == ST_OPEN);

endmodule

// File: rtl/sio_index_reg.sv
module sio_index_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] index_q
);

  logic [DW-1:0] index_d;

  always_comb begin
    index_d = index_q;
    if (load) index_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) index_q <= '0;
    else        index_q <= index_d;
  end

endmodule

// File: rtl/sio_reg_file.sv
module sio_reg_file #(
  parameter int          DW          = 8,
  parameter int          AW          = 16,
  parameter logic [7:0]  LDN_IDX     = 8'h07,
  parameter logic [7:0]  DEVID_IDX   = 8'h20,
  parameter logic [7:0]  ACT_IDX     = 8'h30,
  parameter logic [7:0]  BASE_LO_IDX = 8'h66,
  parameter logic [7:0]  EM_LDN      = 8'h0C,
  parameter logic [7:0]  DEV_ID      = 8'hC6,
  parameter logic [15:0] BASE_RST    = 16'h0A2E,
  parameter logic        ACT_RST     = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    index,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_val,
  output logic [DW-1:0] ldn_q,
  output logic          act_q,
  output logic [AW-1:0] base_q
);

  localparam int NB = AW / DW;

  logic [DW-1:0] ldn_d;
  logic          act_d;
  logic          em_sel;
  logic [DW-1:0] base_byte [NB];

  assign em_sel = (ldn_q == EM_LDN);

  always_comb begin
    ldn_d = ldn_q;
    if (wr_en && index == LDN_IDX) ldn_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ldn_q <= '0;
    else        ldn_q <= ldn_d;
  end

  always_comb begin
    act_d = act_q;
    if (wr_en && em_sel && index == ACT_IDX) act_d = wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= ACT_RST;
    else        act_q <= act_d;
  end

  for (genvar g = 0; g < NB; g++) begin : g_base
    localparam logic [7:0] MY_IDX = BASE_LO_IDX + 8'(g);
    logic [DW-1:0] byte_d;

    always_comb begin
      byte_d = base_byte[g];
      if (wr_en && em_sel && index == MY_IDX) byte_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) base_byte[g] <= BASE_RST[g*DW +: DW];
      else        base_byte[g] <= byte_d;
    end

    assign base_q[g*DW +: DW] = base_byte[g];
  end

  always_comb begin
    rd_val = '0;
    if (index == LDN_IDX) begin
      rd_val = ldn_q;
    end else if (index == DEVID_IDX) begin
      rd_val = DEV_ID;
    end else if (em_sel) begin
      if (index == ACT_IDX) rd_val = {{(DW-1){1'b0}}, act_q};
      for (int b = 0; b < NB; b++) begin
        if (index == BASE_LO_IDX + 8'(b)) rd_val = base_byte[b];
      end
    end
  end

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter bit          ID_ALT     = 1'b0,
  parameter logic [7:0]  UNLOCK_KEY = 8'h55,
  parameter logic [7:0]  LOCK_KEY   = 8'hAA,
  parameter logic [7:0]  EM_LDN     = 8'h0C,
  parameter logic [15:0] BASE_RST   = 16'h0A2E,
  parameter logic        ACT_RST    = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_addr,
  input  logic       wr_stb,
  input  logic       rd_stb,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data
);

  localparam int         DW      = 8;
  localparam int         AW      = 16;
  localparam logic [7:0] DEV_ID  = pick_id(ID_ALT);

  logic          unlocked;
  logic          idx_load;
  logic          idx_wr;
  logic          dat_wr;
  logic [DW-1:0] index_q;
  logic [DW-1:0] reg_rd;
  logic [DW-1:0] ldn_q;
  logic          act_q;
  logic [AW-1:0] base_q;
  logic [DW-1:0] rd_mux;
  logic [DW-1:0] rd_q, rd_d;

  assign idx_wr = wr_stb & ~cfg_addr;
  assign dat_wr = wr_stb & cfg_addr & unlocked;

  sio_key_lock #(
    .DW(DW), .UNLOCK_KEY(UNLOCK_KEY), .LOCK_KEY(LOCK_KEY)
  ) u_lock (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .wr_data(wr_data),
    .unlocked(unlocked), .idx_load(idx_load)
  );

  sio_index_reg #(.DW(DW)) u_idx (
    .clk(clk), .rst_n(rst_n), .load(idx_load), .din(wr_data),
    .index_q(index_q)
  );

  sio_reg_file #(
    .DW(DW), .AW(AW), .EM_LDN(EM_LDN), .DEV_ID(DEV_ID),
    .BASE_RST(BASE_RST), .ACT_RST(ACT_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(dat_wr), .index(index_q),
    .wr_data(wr_data), .rd_val(reg_rd), .ldn_q(ldn_q), .act_q(act_q),
    .base_q(base_q)
  );

  always_comb begin
    if (!unlocked)     rd_mux = LOCKED_READ;
    else if (cfg_addr) rd_mux = reg_rd;
    else               rd_mux = index_q;
  end

  always_comb begin
    rd_d = rd_q;
    if (rd_stb) rd_d = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= LOCKED_READ;
    else        rd_q <= rd_d;
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter logic [7:0] UNLOCK_KEY = 8'h55,
  parameter logic [7:0] LOCK_KEY   = 8'hAA,
  parameter logic [7:0] EM_LDN     = 8'h0C,
  parameter logic [7:0] DEV_ID     = 8'hC6
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_addr,
  input logic        wr_stb,
  input logic        rd_stb,
  input logic [7:0]  wr_data,
  input logic [7:0]  rd_data,
  input logic        unlocked,
  input logic [7:0]  index_q,
  input logic [7:0]  ldn_q,
  input logic        act_q,
  input logic [15:0] base_q
);

  p_unlock_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && wr_stb && !cfg_addr && wr_data == UNLOCK_KEY) |=> unlocked);

  p_locked_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && !(wr_stb && !cfg_addr && wr_data == UNLOCK_KEY)) |=> !unlocked);

  p_locked_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && rd_stb) |=> rd_data == 8'hFF);

  p_locked_regs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> ($stable(ldn_q) && $stable(act_q) && $stable(base_q)));

  p_lock_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && wr_stb && !cfg_addr && wr_data == LOCK_KEY) |=> (!unlocked && $stable(index_q)));

  p_index_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && wr_stb && !cfg_addr && wr_data != LOCK_KEY) |=> index_q == $past(wr_data));

  p_devid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && rd_stb && cfg_addr && index_q == 8'h20) |=> rd_data == DEV_ID);

  p_act_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && rd_stb && cfg_addr && index_q == 8'h30 && ldn_q == EM_LDN) |=> rd_data[7:1] == 7'd0);

  p_other_bank_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ldn_q != EM_LDN) |=> ($stable(act_q) && $stable(base_q)));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));

endmodule

bind sio_cfg_port sio_cfg_port_chk #(
  .UNLOCK_KEY(UNLOCK_KEY), .LOCK_KEY(LOCK_KEY), .EM_LDN(EM_LDN), .DEV_ID(DEV_ID)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .wr_stb(wr_stb),
  .rd_stb(rd_stb), .wr_data(wr_data), .rd_data(rd_data),
  .unlocked(unlocked), .index_q(index_q), .ldn_q(ldn_q), .act_q(act_q),
  .base_q(base_q)
);

// File: tb/sim_sio_cfg_port.sv
`timescale 1ns/1ps
module sim_sio_cfg_port;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_addr = 1'b0;
  logic       wr_stb = 1'b0;
  logic       rd_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;
  string tag = "R1";

  always #10 clk = ~clk;

  sio_cfg_port u0 (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .wr_stb(wr_stb),
    .rd_stb(rd_stb), .wr_data(wr_data), .rd_data(rd_data)
  );

  // behavioural reference
  int m_open, m_idx, m_ldn, m_act, m_base, m_rd;

  function automatic int model_read(input int a);
    if (m_open == 0) return 255;
    if (a == 0) return m_idx;
    if (m_idx == 7) return m_ldn;
    if (m_idx == 32) return 198;
    if (m_ldn != 12) return 0;
    if (m_idx == 48) return m_act;
    if (m_idx == 102) return m_base % 256;
    if (m_idx == 103) return m_base / 256;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_open = 0; m_idx = 0; m_ldn = 0; m_act = 1; m_base = 2606; m_rd = 255;
    end else begin
      if (rd_stb) m_rd = model_read(int'(cfg_addr));
      if (wr_stb) begin
        if (!cfg_addr) begin
          if (m_open == 0) begin
            if (wr_data == 8'h55) m_open = 1;
          end else if (wr_data == 8'hAA) m_open = 0;
          else m_idx = int'(wr_data);
        end else if (m_open != 0) begin
          if (m_idx == 7) m_ldn = int'(wr_data);
          else if (m_ldn == 12) begin
            if (m_idx == 48) m_act = int'(wr_data) % 2;
            else if (m_idx == 102) m_base = (m_base / 256) * 256 + int'(wr_data);
            else if (m_idx == 103) m_base = (m_base % 256) + int'(wr_data) * 256;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      n_cmp++;
      if (int'(rd_data) != m_rd) begin
        n_bad++;
        $display("FAIL %s model compare: actual %02h expected %02h", tag, rd_data, m_rd[7:0]);
      end
    end
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wr(input logic a, input logic [7:0] v);
    @(negedge clk);
    cfg_addr = a; wr_stb = 1'b1; wr_data = v;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic rd_chk(input logic a, input logic [7:0] exp, input string t);
    tag = t;
    @(negedge clk);
    cfg_addr = a; rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    n_cmp++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s directed read: actual %02h expected %02h", t, rd_data, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    // R1 reset value of rd_data
    n_cmp++;
    if (rd_data !== 8'hFF) begin
      n_bad++;
      $display("FAIL R1 reset rd_data: actual %02h expected ff", rd_data);
    end
    rst_n = 1'b1;
    idle(2);
    rd_chk(1'b1, 8'hFF, "R3");
    rd_chk(1'b0, 8'hFF, "R3");
    wr(1'b0, 8'h20);                 // R2 ignored while locked
    rd_chk(1'b1, 8'hFF, "R2");
    wr(1'b1, 8'h12);                 // R3 ignored write
    wr(1'b0, 8'h55);                 // R2 unlock
    rd_chk(1'b0, 8'h00, "R2");       // index untouched by locked write
    wr(1'b0, 8'h20);
    rd_chk(1'b1, 8'hC6, "R7");
    wr(1'b1, 8'h99);
    rd_chk(1'b1, 8'hC6, "R7");
    wr(1'b0, 8'h07);
    rd_chk(1'b1, 8'h00, "R1");       // ldn reset 0
    wr(1'b0, 8'h30);
    rd_chk(1'b1, 8'h00, "R10");
    wr(1'b1, 8'h00);                 // wrong bank, ignored
    wr(1'b0, 8'h07);
    wr(1'b1, 8'h0C);
    rd_chk(1'b1, 8'h0C, "R6");
    wr(1'b0, 8'h30);
    rd_chk(1'b0, 8'h30, "R5");
    rd_chk(1'b1, 8'h01, "R1");       // activate default
    wr(1'b1, 8'hFE);
    rd_chk(1'b1, 8'h00, "R8");
    wr(1'b1, 8'hFF);
    rd_chk(1'b1, 8'h01, "R8");
    wr(1'b0, 8'h66);
    rd_chk(1'b1, 8'h2E, "R1");
    wr(1'b0, 8'h67);
    rd_chk(1'b1, 8'h0A, "R9");
    wr(1'b1, 8'h12);
    wr(1'b0, 8'h66);
    wr(1'b1, 8'h34);
    rd_chk(1'b1, 8'h34, "R9");
    wr(1'b0, 8'h67);
    rd_chk(1'b1, 8'h12, "R9");
    wr(1'b0, 8'h07);
    wr(1'b1, 8'h03);
    wr(1'b0, 8'h66);
    rd_chk(1'b1, 8'h00, "R10");
    wr(1'b1, 8'h77);
    wr(1'b0, 8'h07);
    wr(1'b1, 8'h0C);
    wr(1'b0, 8'h66);
    rd_chk(1'b1, 8'h34, "R10");
    wr(1'b0, 8'h40);
    rd_chk(1'b1, 8'h00, "R10");
    wr(1'b0, 8'h67);
    rd_chk(1'b1, 8'h12, "R11");
    idle(5);
    n_cmp++;
    if (rd_data !== 8'h12) begin
      n_bad++;
      $display("FAIL R11 hold: actual %02h expected 12", rd_data);
    end
    wr(1'b0, 8'hAA);                 // R4 lock
    rd_chk(1'b1, 8'hFF, "R4");
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h55);
    rd_chk(1'b0, 8'h67, "R4");       // index kept across lock
    rd_chk(1'b1, 8'h12, "R3");       // locked write had no effect
    idle(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule